// File: doc/BRIEF.md
# Detector Busy and Multi-Event Buffer Controller

This block runs the front-end readout control for one tracking detector. A level-0 trigger strobe makes the detector busy in the same cycle, so no second event can enter. The block then waits for the level-1 decision on that event. A reject drops busy. An accept stores the event identifier in a four-slot multi-event buffer and keeps busy high for a fixed collection time. The stored event then waits for its level-2 decision, which is matched by identifier.

Buffered events leave the buffer strictly oldest first, one at a time. When the oldest event has a level-2 accept and the downstream link reports ready, a timed readout starts. After the readout time there is a short reset time, and then the slot is freed. When the oldest event has a level-2 reject, it is discarded over a throw time and its slot is freed without any readout. While all four slots are occupied, busy stays asserted, so the trigger system holds off new events. The collection, readout, reset and throw times are parameters counted in clock cycles. The readout time is chosen by a detector-type parameter (slow or fast variant).

Top module: `det_busy_ctrl`

## Requirements
- R1: An `l0Strobe` accepted while `busy` is low raises `busy` in that same cycle. An `l0Strobe` that arrives while `busy` is high is ignored.
- R2: An `l1Strobe` with `l1Accept`=0 while waiting for level 1 makes `busy` low from the next cycle and leaves `occupancy` unchanged.
- R3: An `l1Strobe` with `l1Accept`=1 while waiting for level 1 stores `l1EvId`. `occupancy` rises by one from the next cycle, and `busy` stays high for exactly COLLECT_CYC cycles after that edge.
- R4: While `occupancy` equals 4, `busy` is high. Level-0 and level-1 strobes in that time change neither `busy` nor `occupancy`.
- R5: `rdStart` is a one-cycle pulse. It rises only after the oldest buffered event has received a level-2 accept (`l2Strobe` with `l2Accept`=1 and a matching `l2EvId`) while `linkReady` is high.
- R6: `rdDone` pulses exactly READ_CYC cycles after `rdStart` (20 for the slow type, 10 for the fast type). `occupancy` drops by one RESET_CYC cycles after `rdDone`.
- R7: A level-2 reject marks the matching event for discard. Once that event is the oldest and the readout engine is idle, its slot is freed THROW_CYC+1 cycles after the decision edge, and no `rdStart` is produced for it.
- R8: Events drain in arrival order. A younger event that has been accepted at level 2 is not read out while an older event still awaits its level-2 decision.
- R9: A level-2 strobe whose `l2EvId` matches no event that is awaiting level 2 pulses `l2Error` for one cycle from the next edge and changes no buffer state.
- R10: `occupancy` is a 3-bit count of stored events, 0 after reset and never above 4.
- R11: An `l1Strobe` while not waiting for level 1 is ignored. `busy` and `occupancy` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| l0Strobe | input | 1 | Level-0 trigger strobe |
| l1Strobe | input | 1 | Level-1 decision strobe |
| l1Accept | input | 1 | Level-1 decision: 1 accept, 0 reject |
| l1EvId | input | ID_W | Identifier of the event accepted at level 1 |
| l2Strobe | input | 1 | Level-2 decision strobe |
| l2Accept | input | 1 | Level-2 decision: 1 accept, 0 reject |
| l2EvId | input | ID_W | Identifier the level-2 decision refers to |
| linkReady | input | 1 | Downstream link can take a readout |
| busy | output | 1 | Detector busy toward the trigger system |
| occupancy | output | 3 | Number of events held in the buffer (0 to 4) |
| rdStart | output | 1 | One-cycle pulse: a readout begins |
| rdDone | output | 1 | One-cycle pulse: a readout ends |
| l2Error | output | 1 | One-cycle pulse: level-2 identifier not matched |

## Verification
A wrong trigger phase shows up on `busy` within one cycle of the level-0 or level-1 strobe. A wrong collection count shows up as a busy window that is too short or too long. A corrupted slot status or identifier surfaces at the next level-2 decision: it appears as a spurious `l2Error`, as a missing or early `rdStart`, or as an out-of-order readout. A timer fault in the readout engine appears as a shifted `rdDone` pulse, or as an `occupancy` decrement that comes too early or too late. All of these are measured to the exact cycle.

// File: rtl/det_busy_pkg.sv
package det_busy_pkg;

  // Per-slot decision state
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // waiting for level 2
    ST_KEEP = 2'd1,  // level-2 accepted, to be read out
    ST_DROP = 2'd2   // level-2 rejected, to be thrown
  } slot_st_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } dp_cmd_t;

endpackage

// File: rtl/det_busy_dp.sv
module det_busy_dp
  import det_busy_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ID_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_cmd_t          cmd,
  input  logic [ID_W-1:0]  l1EvId,
  input  logic             l2Strobe,
  input  logic             l2Accept,
  input  logic [ID_W-1:0]  l2EvId,
  output logic             headVld,
  output slot_st_e         headSt,
  output logic             full,
  output logic [CNT_W-1:0] occupancy,
  output logic             l2Error
);

  logic [ID_W-1:0]  idMem [DEPTH];
  slot_st_e         stMem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic [PTR_W-1:0] hitIdx;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // First slot awaiting level 2 with a matching identifier
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit && vld[i] && stMem[i] == ST_WAIT && idMem[i] == l2EvId) begin
        hit    = 1'b1;
        hitIdx = PTR_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        idMem[i] <= '0;
        stMem[i] <= ST_WAIT;
      end
      vld     <= '0;
      headPtr <= '0;
      tailPtr <= '0;
      cnt     <= '0;
      l2Error <= 1'b0;
    end else begin
      l2Error <= l2Strobe && !hit;
      if (l2Strobe && hit)
        stMem[hitIdx] <= l2Accept ? ST_KEEP : ST_DROP;
      if (cmd.push) begin
        idMem[tailPtr] <= l1EvId;
        stMem[tailPtr] <= ST_WAIT;
        vld[tailPtr]   <= 1'b1;
        tailPtr        <= nextPtr(tailPtr);
      end
      if (cmd.pop) begin
        vld[headPtr] <= 1'b0;
        headPtr      <= nextPtr(headPtr);
      end
      cnt <= cnt + CNT_W'(cmd.push) - CNT_W'(cmd.pop);
    end
  end

  assign headVld   = vld[headPtr];
  assign headSt    = stMem[headPtr];
  assign full      = (cnt == CNT_W'(DEPTH));
  assign occupancy = cnt;

  // R10
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  // R4
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> !full);

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> headVld && cnt != '0);

endmodule

// File: rtl/det_busy_ctl.sv
module det_busy_ctl
  import det_busy_pkg::*;
#(
  parameter int COLLECT_CYC = 4,
  parameter int READ_CYC    = 20,
  parameter int RESET_CYC   = 2,
  parameter int THROW_CYC   = 3,
  localparam int MAX_A = (COLLECT_CYC > READ_CYC) ? COLLECT_CYC : READ_CYC,
  localparam int MAX_B = (RESET_CYC > THROW_CYC) ? RESET_CYC : THROW_CYC,
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CTR_W = $clog2(MAXC + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     l0Strobe,
  input  logic     l1Strobe,
  input  logic     l1Accept,
  input  logic     linkReady,
  input  logic     headVld,
  input  slot_st_e headSt,
  input  logic     full,
  output dp_cmd_t  cmd,
  output logic     busy,
  output logic     rdStart,
  output logic     rdDone
);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT_L1, PH_COLLECT} phase_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_READ, SQ_RESET, SQ_THROW} seq_e;

  phase_e           phase;
  seq_e             seqState;
  logic [CTR_W-1:0] colCtr, seqCtr;
  logic             busyState, l0Take;

  assign busyState = (phase != PH_IDLE) || full;
  assign l0Take    = l0Strobe && !busyState;
  assign busy      = busyState || l0Strobe;
  assign cmd.push  = (phase == PH_WAIT_L1) && l1Strobe && l1Accept;
  assign cmd.pop   = (seqState == SQ_RESET || seqState == SQ_THROW) && seqCtr == '0;

  // Trigger phase: level 0 then level 1 then collection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      colCtr <= '0;
    end else begin
      unique case (phase)
        PH_IDLE:    if (l0Take) phase <= PH_WAIT_L1;
        PH_WAIT_L1: if (l1Strobe) begin
          if (l1Accept) begin
            phase  <= PH_COLLECT;
            colCtr <= CTR_W'(COLLECT_CYC - 1);
          end else begin
            phase <= PH_IDLE;
          end
        end
        PH_COLLECT: begin
          if (colCtr == '0) phase <= PH_IDLE;
          else colCtr <= colCtr - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Readout engine: serves the oldest slot only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= SQ_IDLE;
      seqCtr   <= '0;
      rdStart  <= 1'b0;
      rdDone   <= 1'b0;
    end else begin
      rdStart <= 1'b0;
      rdDone  <= 1'b0;
      unique case (seqState)
        SQ_IDLE: if (headVld) begin
          if (headSt == ST_KEEP && linkReady) begin
            seqState <= SQ_READ;
            seqCtr   <= CTR_W'(READ_CYC - 1);
            rdStart  <= 1'b1;
          end else if (headSt == ST_DROP) begin
            seqState <= SQ_THROW;
            seqCtr   <= CTR_W'(THROW_CYC - 1);
          end
        end
        SQ_READ: begin
          if (seqCtr == '0) begin
            seqState <= SQ_RESET;
            seqCtr   <= CTR_W'(RESET_CYC - 1);
            rdDone   <= 1'b1;
          end else seqCtr <= seqCtr - 1'b1;
        end
        SQ_RESET, SQ_THROW: begin
          if (seqCtr == '0) seqState <= SQ_IDLE;
          else seqCtr <= seqCtr - 1'b1;
        end
        default: seqState <= SQ_IDLE;
      endcase
    end
  end

  // R4
  busy_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> busy);

  // R5
  link_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |-> $past(linkReady));

  // R3
  l1acc_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |=> busy);

  // R6
  start_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> !rdStart && $past(seqState == SQ_READ));

endmodule

// File: rtl/det_busy_ctrl.sv
module det_busy_ctrl
  import det_busy_pkg::*;
#(
  parameter int ID_W        = 8,
  parameter int DEPTH       = 4,
  parameter bit FAST_DET    = 1'b0,
  parameter int READ_SLOW   = 20,
  parameter int READ_FAST   = 10,
  parameter int COLLECT_CYC = 4,
  parameter int RESET_CYC   = 2,
  parameter int THROW_CYC   = 3,
  localparam int READ_CYC   = FAST_DET ? READ_FAST : READ_SLOW,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             l0Strobe,
  input  logic             l1Strobe,
  input  logic             l1Accept,
  input  logic [ID_W-1:0]  l1EvId,
  input  logic             l2Strobe,
  input  logic             l2Accept,
  input  logic [ID_W-1:0]  l2EvId,
  input  logic             linkReady,
  output logic             busy,
  output logic [CNT_W-1:0] occupancy,
  output logic             rdStart,
  output logic             rdDone,
  output logic             l2Error
);

  dp_cmd_t  cmd;
  logic     headVld, full;
  slot_st_e headSt;

  det_busy_ctl #(
    .COLLECT_CYC(COLLECT_CYC), .READ_CYC(READ_CYC),
    .RESET_CYC(RESET_CYC), .THROW_CYC(THROW_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .l0Strobe(l0Strobe), .l1Strobe(l1Strobe),
    .l1Accept(l1Accept), .linkReady(linkReady), .headVld(headVld),
    .headSt(headSt), .full(full), .cmd(cmd), .busy(busy),
    .rdStart(rdStart), .rdDone(rdDone)
  );

  det_busy_dp #(.DEPTH(DEPTH), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .l1EvId(l1EvId),
    .l2Strobe(l2Strobe), .l2Accept(l2Accept), .l2EvId(l2EvId),
    .headVld(headVld), .headSt(headSt), .full(full),
    .occupancy(occupancy), .l2Error(l2Error)
  );

endmodule

// File: tb/det_busy_ctrl_bench.sv
`timescale 1ns/1ps
module det_busy_ctrl_bench;

  localparam int ID_W = 8, COLLECT = 4, READ = 20, RESETC = 2, THROW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic l0Strobe = 0, l1Strobe = 0, l1Accept = 0, l2Strobe = 0, l2Accept = 0;
  logic linkReady = 0;
  logic [ID_W-1:0] l1EvId = '0, l2EvId = '0;
  logic busy, rdStart, rdDone, l2Error;
  logic [2:0] occupancy;

  int tests = 0, fails = 0, starts = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  det_busy_ctrl u_det_busy_ctrl (
    .clk(clk), .rstN(rstN), .l0Strobe(l0Strobe), .l1Strobe(l1Strobe),
    .l1Accept(l1Accept), .l1EvId(l1EvId), .l2Strobe(l2Strobe),
    .l2Accept(l2Accept), .l2EvId(l2EvId), .linkReady(linkReady),
    .busy(busy), .occupancy(occupancy), .rdStart(rdStart),
    .rdDone(rdDone), .l2Error(l2Error)
  );

  always @(negedge clk) begin
    if (rdStart) starts++;
    cyc++;
    if (cyc > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      finished = 1;
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseL0();
    l0Strobe = 1; tick(1); l0Strobe = 0;
  endtask

  task automatic pulseL1(input bit acc, input int id);
    l1Strobe = 1; l1Accept = acc; l1EvId = ID_W'(id);
    tick(1); l1Strobe = 0; l1Accept = 0;
  endtask

  task automatic pulseL2(input bit acc, input int id);
    l2Strobe = 1; l2Accept = acc; l2EvId = ID_W'(id);
    tick(1); l2Strobe = 0; l2Accept = 0;
  endtask

  task automatic storeEvent(input int id);
    pulseL0(); pulseL1(1, id); tick(COLLECT);
  endtask

  task automatic t_reset();
    chk("R10 reset occupancy", occupancy, 0);
    chk("R1 reset busy", busy, 0);
    chk("R5 reset rdStart", rdStart, 0);
    chk("R9 reset l2Error", l2Error, 0);
  endtask

  task automatic t_l1Reject();
    l0Strobe = 1; #1;
    chk("R1 busy same cycle as l0", busy, 1);
    tick(1); l0Strobe = 0;
    chk("R1 busy held after l0", busy, 1);
    pulseL0();
    chk("R1 second l0 while busy keeps busy", busy, 1);
    pulseL1(0, 7);
    chk("R2 busy low after l1 reject", busy, 0);
    chk("R2 occupancy after l1 reject", occupancy, 0);
  endtask

  task automatic t_l1Accept();
    pulseL0();
    pulseL1(1, 5);
    chk("R3 occupancy after l1 accept", occupancy, 1);
    tick(COLLECT - 1);
    chk("R3 busy at end of collection", busy, 1);
    tick(1);
    chk("R3 busy released after collection", busy, 0);
  endtask

  task automatic t_stray();
    pulseL1(1, 44);
    chk("R11 stray l1 occupancy", occupancy, 1);
    chk("R11 stray l1 busy", busy, 0);
  endtask

  task automatic t_readout();
    int s0, n;
    s0 = starts;
    pulseL2(1, 5);
    tick(6);
    chk("R5 no readout while link not ready", starts - s0, 0);
    linkReady = 1;
    n = 0;
    while (!rdStart && n < 10) begin tick(1); n++; end
    chk("R5 rdStart after link ready", rdStart, 1);
    tick(1);
    chk("R5 rdStart is one cycle", rdStart, 0);
    n = 1;
    while (!rdDone && n < 100) begin tick(1); n++; end
    chk("R6 readout length", n, READ);
    tick(RESETC - 1);
    chk("R6 occupancy held during reset time", occupancy, 1);
    tick(1);
    chk("R6 occupancy freed after reset time", occupancy, 0);
  endtask

  task automatic t_unknown();
    pulseL2(1, 9);
    chk("R9 l2Error on unknown id", l2Error, 1);
    tick(1);
    chk("R9 l2Error one cycle", l2Error, 0);
    chk("R9 occupancy unchanged", occupancy, 0);
  endtask

  task automatic t_reject();
    int s0;
    storeEvent(3);
    s0 = starts;
    pulseL2(0, 3);
    chk("R7 occupancy right after reject", occupancy, 1);
    tick(THROW);
    chk("R7 occupancy during throw", occupancy, 1);
    tick(1);
    chk("R7 occupancy freed after throw", occupancy, 0);
    chk("R7 no readout for rejected event", starts - s0, 0);
  endtask

  task automatic t_order();
    int s0, n;
    storeEvent(1);
    storeEvent(2);
    s0 = starts;
    pulseL2(1, 2);
    tick(10);
    chk("R8 younger event blocked by older", starts - s0, 0);
    chk("R8 occupancy while blocked", occupancy, 2);
    pulseL2(1, 1);
    n = 0;
    while (occupancy != 0 && n < 200) begin tick(1); n++; end
    chk("R8 both events drained", occupancy, 0);
    chk("R8 two readouts", starts - s0, 2);
  endtask

  task automatic t_full();
    int n;
    linkReady = 0;
    for (int i = 0; i < 4; i++) storeEvent(10 + i);
    chk("R10 occupancy at four", occupancy, 4);
    chk("R4 busy while full", busy, 1);
    pulseL0();
    pulseL1(1, 99);
    tick(COLLECT + 1);
    chk("R4 l0/l1 ignored while full", occupancy, 4);
    chk("R4 busy still high", busy, 1);
    linkReady = 1;
    for (int i = 0; i < 4; i++) pulseL2(1, 10 + i);
    n = 0;
    while (occupancy != 0 && n < 400) begin tick(1); n++; end
    chk("R4 full buffer drained", occupancy, 0);
    chk("R4 busy released after drain", busy, 0);
    pulseL2(1, 12);
    chk("R9 decision for drained id flagged", l2Error, 1);
  endtask

  initial begin
    tick(3);
    rstN = 1;
    tick(1);
    t_reset();
    t_l1Reject();
    t_l1Accept();
    t_stray();
    t_readout();
    t_unknown();
    t_reject();
    t_order();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule